// File: doc/BRIEF.md
# Dynamic Per-Bank Refresh Scheduler

This block lives inside a DRAM memory controller and decides when a per-bank refresh goes out and which bank it targets. Each refresh-interval tick gives every bank one more refresh that it owes. The scheduler pays these debts back one bank at a time. Banks that are idle are served first. A bank with queued requests is left alone so that it does not stall reads. While the controller is draining a write batch, any bank that is not busy can take its refresh.

A refresh makes one bank unavailable for a programmable number of cycles, given on `rfc_cycles_i`. The other banks stay usable during that time. Only one bank is refreshed at a time. A bank that has reached the maximum postponement is refreshed immediately, whatever its queue or busy state. When several banks are eligible, a rotating pointer chooses between them, so that no bank is favoured over time.

Top module: `rfs_bank_refresh_sched`

## Requirements
- R1: After reset, no refresh is requested, `in_refresh_o` is zero, no bank owes a refresh, and the rotating pointer is at bank 0.
- R2: Each cycle with `tick_i` high adds one owed refresh to every bank. A refresh is only issued to a bank that owes one. Every owed refresh is issued once the banks are idle.
- R3: A bank's owed count never goes above 8. Ticks that arrive while a bank owes 8 are dropped.
- R4: Outside drain mode, a bank that owes a refresh can take it only if its pending count is zero and its busy flag is low.
- R5: Outside drain mode, a bank with a nonzero pending count is not refreshed unless it owes 8. Its refresh is postponed until its pending count returns to zero.
- R6: If any bank owes 8, only banks owing 8 are eligible. One of them is refreshed without regard to its pending count or busy flag.
- R7: While `drain_i` is high, any bank that owes a refresh and is not busy is eligible, whatever its pending count.
- R8: Among the eligible banks, the first one found going upward from the pointer (wrapping around) is chosen. After an issue, the pointer moves to the chosen bank plus one, modulo 8.
- R9: An issue appears as a one-cycle `ref_req_o` pulse, with the chosen bank on `ref_bank_o`. That bank's bit of `in_refresh_o` is high for `rfc_cycles_i` cycles, starting in the pulse cycle; a value of 0 counts as 1. The decision is registered, so the pulse follows the cycle in which the bank became eligible.
- R10: At most one bit of `in_refresh_o` is high at any time. A new pulse comes no earlier than the cycle after `in_refresh_o` returns to zero.
- R11: A busy bank is not refreshed unless it owes 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Refresh-interval tick; credits one refresh to every bank |
| drain_i | input | 1 | Controller is draining a write batch |
| pend_cnt_i | input | NUM_BANKS*PEND_W | Pending request count per bank, bank b at bits [b*PEND_W +: PEND_W] |
| busy_i | input | NUM_BANKS | Per-bank busy flag, bit b for bank b |
| rfc_cycles_i | input | RFC_W | Refresh latency in cycles (0 treated as 1) |
| ref_req_o | output | 1 | One-cycle refresh issue pulse |
| ref_bank_o | output | $clog2(NUM_BANKS) | Bank of the refresh being issued |
| in_refresh_o | output | NUM_BANKS | Bank b is under refresh while bit b is high |

## Verification
The selection logic is driven with several directed patterns, and each one separates one rule from the others:
- All banks idle after one tick. This shows the pure rotation order starting from bank 0.
- Only one bank holding a pending count. This shows postponement, and that the refresh is paid back once the queue empties.
- Every bank pending while drain mode toggles. This tells the drain path apart from the idle path.
- A burst of ten back-to-back ticks against permanently pending banks. This separates saturation at 8, through the total number of refreshes issued, from the forced refreshes counted before the queues are released.
- Busy masks and short or zero latencies. These test the busy rule and the latency window.

Seeded random mixes of ticks, pending counts, busy flags and drain windows are then compared cycle by cycle against a bench model built from the requirements.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

    // Which eligibility rule picks the next refresh target
    typedef enum logic [1:0] {
        SEL_FORCE = 2'd0,
        SEL_DRAIN = 2'd1,
        SEL_IDLE  = 2'd2
    } sel_mode_e;

    function automatic int rot_next(input int idx, input int n);
        return (idx + 1) % n;
    endfunction

endpackage

// File: rtl/rfs_owed_ctr.sv
module rfs_owed_ctr #(
    parameter int MAX_OWED = 8,
    parameter int OWED_W   = $clog2(MAX_OWED + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              credit_i,
    input  logic              debit_i,
    output logic [OWED_W-1:0] owed_o,
    output logic              at_max_o,
    output logic              has_debt_o
);

    logic [OWED_W-1:0] owed_d, owed_q;

    always_comb begin
        owed_d = owed_q;
        if (credit_i && (owed_q != OWED_W'(MAX_OWED))) begin
            owed_d = owed_d + OWED_W'(1);
        end
        if (debit_i) begin
            owed_d = owed_d - OWED_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owed_q <= '0;
        end else begin
            owed_q <= owed_d;
        end
    end

    assign owed_o     = owed_q;
    assign at_max_o   = (owed_q == OWED_W'(MAX_OWED));
    assign has_debt_o = (owed_q != '0);

    AST_OWED_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        owed_q <= OWED_W'(MAX_OWED)); // R3

    AST_DEBIT_NEEDS_DEBT: assert property (@(posedge clk) disable iff (!rst_n)
        debit_i |-> owed_q != '0); // R2

endmodule

// File: rtl/rfs_rot_pick.sv
module rfs_rot_pick #(
    parameter int NUM_BANKS = 8,
    parameter int BANK_W    = $clog2(NUM_BANKS)
) (
    input  logic [NUM_BANKS-1:0] req_i,
    input  logic [BANK_W-1:0]    ptr_i,
    output logic                 vld_o,
    output logic [BANK_W-1:0]    idx_o
);

    always_comb begin
        int cand;
        vld_o = 1'b0;
        idx_o = '0;
        cand  = 0;
        for (int k = 0; k < NUM_BANKS; k++) begin
            cand = (int'(ptr_i) + k) % NUM_BANKS;
            if (!vld_o && req_i[cand]) begin
                vld_o = 1'b1;
                idx_o = BANK_W'(cand);
            end
        end
    end

endmodule

// File: rtl/rfs_bank_refresh_sched.sv
module rfs_bank_refresh_sched
    import rfs_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int PEND_W    = 4,
    parameter int MAX_OWED  = 8,
    parameter int RFC_W     = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        tick_i,
    input  logic                        drain_i,
    input  logic [NUM_BANKS*PEND_W-1:0] pend_cnt_i,
    input  logic [NUM_BANKS-1:0]        busy_i,
    input  logic [RFC_W-1:0]            rfc_cycles_i,
    output logic                        ref_req_o,
    output logic [$clog2(NUM_BANKS)-1:0] ref_bank_o,
    output logic [NUM_BANKS-1:0]        in_refresh_o
);

    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int OWED_W = $clog2(MAX_OWED + 1);

    typedef struct packed {
        logic [RFC_W-1:0]  timer;
        logic [BANK_W-1:0] act_bank;
        logic              req;
        logic [BANK_W-1:0] bank;
        logic [BANK_W-1:0] ptr;
    } sched_st_t;

    sched_st_t st_d, st_q;

    logic [NUM_BANKS-1:0] at_max, has_debt, pend_zero, debit;
    logic [NUM_BANKS-1:0] force_v, drain_v, idle_v, cand_v;
    logic                 refreshing;
    logic                 pick_vld;
    logic [BANK_W-1:0]    pick_idx;
    sel_mode_e            sel_mode;

    assign refreshing = (st_q.timer != '0);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [OWED_W-1:0] owed;

        rfs_owed_ctr #(
            .MAX_OWED (MAX_OWED),
            .OWED_W   (OWED_W)
        ) i_owed (
            .clk        (clk),
            .rst_n      (rst_n),
            .credit_i   (tick_i),
            .debit_i    (debit[b]),
            .owed_o     (owed),
            .at_max_o   (at_max[b]),
            .has_debt_o (has_debt[b])
        );

        assign pend_zero[b] = (pend_cnt_i[b*PEND_W +: PEND_W] == '0);
        assign force_v[b]   = at_max[b];
        assign drain_v[b]   = has_debt[b] && !busy_i[b];
        assign idle_v[b]    = has_debt[b] && !busy_i[b] && pend_zero[b];
        assign debit[b]     = pick_vld && (pick_idx == BANK_W'(b));

        AST_ISSUE_POSTPONE_OK: assert property (@(posedge clk) disable iff (!rst_n)
            (ref_req_o && ref_bank_o == BANK_W'(b)) |->
                $past(at_max[b] || drain_i || pend_zero[b])); // R5
        AST_ISSUE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
            (ref_req_o && ref_bank_o == BANK_W'(b)) |->
                $past(at_max[b] || !busy_i[b])); // R11
        AST_ISSUE_HAS_DEBT: assert property (@(posedge clk) disable iff (!rst_n)
            (ref_req_o && ref_bank_o == BANK_W'(b)) |-> $past(has_debt[b])); // R2
    end

    always_comb begin
        if (|at_max) begin
            sel_mode = SEL_FORCE;
        end else if (drain_i) begin
            sel_mode = SEL_DRAIN;
        end else begin
            sel_mode = SEL_IDLE;
        end
        cand_v = '0;
        if (!refreshing) begin
            case (sel_mode)
                SEL_FORCE: cand_v = force_v;
                SEL_DRAIN: cand_v = drain_v;
                default:   cand_v = idle_v;
            endcase
        end
    end

    rfs_rot_pick #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_W    (BANK_W)
    ) i_pick (
        .req_i (cand_v),
        .ptr_i (st_q.ptr),
        .vld_o (pick_vld),
        .idx_o (pick_idx)
    );

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;
        if (refreshing) begin
            st_d.timer = st_q.timer - RFC_W'(1);
        end
        if (pick_vld) begin
            st_d.timer    = (rfc_cycles_i == '0) ? RFC_W'(1) : rfc_cycles_i;
            st_d.act_bank = pick_idx;
            st_d.req      = 1'b1;
            st_d.bank     = pick_idx;
            st_d.ptr      = BANK_W'(rot_next(int'(pick_idx), NUM_BANKS));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        in_refresh_o = '0;
        if (refreshing) begin
            in_refresh_o[st_q.act_bank] = 1'b1;
        end
    end

    assign ref_req_o  = st_q.req;
    assign ref_bank_o = st_q.bank;

    AST_SINGLE_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(in_refresh_o)); // R10
    AST_PULSE_MARKS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req_o |-> in_refresh_o[ref_bank_o]); // R9
    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req_o |=> !ref_req_o); // R9
    AST_NO_ISSUE_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req_o |-> $past(in_refresh_o) == '0); // R10
    AST_FORCE_GOES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        ((in_refresh_o == '0) && (|at_max)) |=> ref_req_o); // R6

endmodule

// File: tb/test_rfs_bank_refresh_sched.sv
module test_rfs_bank_refresh_sched;

    localparam int NB   = 8;
    localparam int PW   = 4;
    localparam int MAXO = 8;
    localparam int RW   = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          drain = 1'b0;
    logic [NB*PW-1:0] pend = '0;
    logic [NB-1:0] busy = '0;
    logic [RW-1:0] rfc = 8'd2;
    logic          ref_req;
    logic [2:0]    ref_bank;
    logic [NB-1:0] in_ref;

    int n_chk = 0;
    int n_bad = 0;
    int seq [0:255];
    int nseq = 0;
    int ref_cyc = 0;
    int multi_cyc = 0;
    bit done = 0;

    always #10 clk = ~clk;

    rfs_bank_refresh_sched #(
        .NUM_BANKS (NB), .PEND_W (PW), .MAX_OWED (MAXO), .RFC_W (RW)
    ) i_rfs_bank_refresh_sched (
        .clk (clk), .rst_n (rst_n), .tick_i (tick), .drain_i (drain),
        .pend_cnt_i (pend), .busy_i (busy), .rfc_cycles_i (rfc),
        .ref_req_o (ref_req), .ref_bank_o (ref_bank), .in_refresh_o (in_ref)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model built from R2..R11
    int m_owed [NB];
    int m_timer, m_bank, m_ptr;
    bit m_req;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NB; b++) m_owed[b] = 0;
            m_timer = 0; m_bank = 0; m_ptr = 0; m_req = 0;
        end else begin
            int pick;
            int c;
            bit anyf;
            bit ok;
            pick = -1;
            anyf = 0;
            for (int b = 0; b < NB; b++) if (m_owed[b] == MAXO) anyf = 1;
            if (m_timer == 0) begin
                for (int k = 0; k < NB; k++) begin
                    c = (m_ptr + k) % NB;
                    if (anyf) ok = (m_owed[c] == MAXO);
                    else ok = (m_owed[c] > 0) && !busy[c] &&
                              (drain || pend[c*PW +: PW] == 0);
                    if (pick < 0 && ok) pick = c;
                end
            end
            m_req = (pick >= 0);
            if (m_timer > 0) m_timer--;
            if (pick >= 0) begin
                m_timer = (rfc == 0) ? 1 : int'(rfc);
                m_bank = pick;
                m_ptr = (pick + 1) % NB;
            end
            for (int b = 0; b < NB; b++) begin
                if (tick && m_owed[b] < MAXO) m_owed[b]++;
                if (b == pick) m_owed[b]--;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R9 pulse vs model", int'(ref_req), int'(m_req));
            if (m_req) check("R8 bank vs model", int'(ref_bank), m_bank);
            check("R9 in_refresh vs model", int'(in_ref),
                  (m_timer != 0) ? (1 << m_bank) : 0);
            if (ref_req && nseq < 256) begin
                seq[nseq] = int'(ref_bank);
                nseq++;
            end
            if (in_ref != 0) ref_cyc++;
            if ($countones(in_ref) > 1) multi_cyc++;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic one_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic quiet();
        int idle = 0;
        int guard = 0;
        while (idle < 30 && guard < 5000) begin
            @(negedge clk);
            if (ref_req || in_ref != 0) idle = 0; else idle++;
            guard++;
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        cyc(5);
        check("R1 reset ref_req", int'(ref_req), 0);
        check("R1 reset in_refresh", int'(in_ref), 0);
        rst_n = 1'b1;
        cyc(10);
        check("R1 no refresh without owed (R2)", nseq, 0);

        // R8 / R2: idle banks, order from pointer 0
        one_tick(); quiet();
        check("R2 one refresh per bank", nseq, 8);
        for (int i = 0; i < 8; i++) check("R8 rotation order from R1 ptr 0", seq[i], i);

        // R5 / R4: bank 0 pending is postponed
        nseq = 0;
        pend[0 +: PW] = 4'd3;
        one_tick(); quiet();
        check("R5 pending bank skipped", nseq, 7);
        for (int i = 0; i < 7; i++) check("R4 idle banks order", seq[i], i + 1);
        pend = '0; quiet();
        check("R5 postponed refresh paid", nseq, 8);
        check("R5 postponed bank", seq[7], 0);

        // R7: drain mode with all banks pending, pointer now 1
        nseq = 0;
        for (int b = 0; b < NB; b++) pend[b*PW +: PW] = 4'd5;
        drain = 1'b1;
        one_tick(); quiet();
        check("R7 drain refreshes all", nseq, 8);
        for (int i = 0; i < 8; i++) check("R7 drain order", seq[i], (i + 1) % 8);
        drain = 1'b0;

        // R5 then R7: several postponed refreshes paid during drain
        nseq = 0;
        one_tick(); one_tick(); one_tick(); quiet();
        check("R5 all pending postponed", nseq, 0);
        drain = 1'b1; quiet();
        check("R7 postponed paid in drain", nseq, 24);
        drain = 1'b0;

        // R3 / R6: ten back-to-back ticks while all banks pending
        nseq = 0;
        rfc = 8'd3;
        @(negedge clk) tick = 1'b1;
        cyc(10);
        tick = 1'b0;
        cyc(150);
        check("R6 forced refreshes under pending", nseq, 9);
        check("R6 first forced bank follows pointer", seq[0], 1);
        pend = '0; quiet();
        check("R3 saturated total refreshes", nseq, 65);

        // R11: busy banks wait
        nseq = 0;
        busy = ~(8'b1 << 5);
        one_tick(); cyc(30);
        check("R11 only non-busy bank", nseq, 1);
        check("R11 bank picked", seq[0], 5);
        busy = '0; quiet();
        check("R11 busy banks served later", nseq, 8);

        // R9 / R10: latency window
        nseq = 0; ref_cyc = 0; rfc = 8'd5;
        one_tick(); quiet();
        check("R9 window of 5 cycles", ref_cyc, 40);
        ref_cyc = 0; rfc = 8'd0;
        one_tick(); quiet();
        check("R9 zero latency counts as 1", ref_cyc, 8);

        // Random phase against the model
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            tick = ($urandom_range(0, 15) == 0);
            if ($urandom_range(0, 63) == 0) drain = ~drain;
            for (int b = 0; b < NB; b++)
                pend[b*PW +: PW] = ($urandom_range(0, 2) == 0) ? PW'($urandom_range(1, 15)) : '0;
            busy = NB'($urandom_range(0, 255)) & NB'($urandom_range(0, 255));
            if ($urandom_range(0, 31) == 0) rfc = RW'($urandom_range(0, 6));
        end
        tick = 1'b0; drain = 1'b0; pend = '0; busy = '0;
        quiet();
        check("R10 never two banks in refresh", multi_cyc, 0);
        finish_run();
    end

endmodule